// File: doc/BRIEF.md
# Ping-Pong Block Byte Streamer

This block sits between a source that delivers data in fixed blocks of 512 bytes and a byte-serial consumer (a renderer) that asks for one byte at a time and cannot wait. It keeps a two-half buffer of 1024 bytes. The source refills one half while the consumer reads from the other. Each refill starts with a one-cycle request pulse, and the source then answers with exactly 512 valid strobes, one byte per strobe.

After its own reset is released, the streamer asks for the first block and holds the consumer in reset until that block is complete. It then asks for the second block straight away. From then on it asks for a refill each time the consumer moves past the last byte of a half. The block runs without end, and holding its reset low stops it.

Top module: `blk_pingpong_streamer`

## Requirements
- R1: While `rst_n` is low, the clock edge drives `blk_req` to 0, `rend_rst_n` to 0 and `byte_data` to 0. In the first cycle after `rst_n` is released, `blk_req` is high.
- R2: `blk_req` is high for exactly one cycle per request. No further pulse is raised while a refill has received fewer than 512 strobes.
- R3: Each refill stores the bytes of its strobes in order, from offset 0 to offset 511 of the half being refilled. Strobes that arrive while no refill is outstanding are ignored.
- R4: `rend_rst_n` stays low until the edge that takes the 512th strobe of the first block. It is high from the cycle after that edge and stays high.
- R5: The cycle after `rend_rst_n` rises, `blk_req` pulses to request the second half, so the first two blocks load back to back.
- R6: When `byte_req` is high at an edge and `rend_rst_n` is high, `byte_data` shows the next buffered byte in the following cycle. Reads start at address 0 and wrap from address 1023 to address 0.
- R7: `byte_req` is ignored while `rend_rst_n` is low. `byte_data` does not change and the read order does not move.
- R8: Reading the byte at address 511 or 1023 empties that half. If no refill is counting, a request for that half pulses in the cycle after the next edge. If a refill is counting, the request pulses in the cycle after the edge that completes that refill. The new bytes go into the half that was emptied.
- R9: Taking `rst_n` low during operation restarts the block. The request, release and read order all start again from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_req | output | 1 | One-cycle pulse asking the source for a 512-byte block |
| src_valid | input | 1 | Source strobe: `src_data` holds a valid byte |
| src_data | input | 8 | Byte from the source |
| byte_req | input | 1 | Consumer asks for the next byte |
| byte_data | output | 8 | Byte handed to the consumer, valid the cycle after the request |
| rend_rst_n | output | 1 | Active-low reset for the consumer |

## Verification
Two functions can fall in the same cycle: a source strobe writing into one half, and a consumer read from the other half. The read can be the one that takes the final byte of its half. The bench provokes this by starting a refill of the lower half while it reads the upper half, with a strobe and a read in the same cycle. It drains the upper half completely while the refill still has strobes to come. It then judges three things: every byte read in those overlapping cycles matches the block written earlier, no request appears while the refill is counting, and the deferred request pulses in the cycle after the refill's last strobe.

// File: rtl/sbuf_pkg.sv
// Package: types shared by the ping-pong streamer modules.
// Assumes: nothing beyond the standard.
package sbuf_pkg;
    // State of the refill engine.
    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_BUSY = 1'b1
    } fill_state_e;
endpackage

// File: rtl/sbuf_ram.sv
// Module: sbuf_ram
// Storage with one write port and one read port. The read is registered,
// and only the read register is cleared by reset.
// Assumes: the write and read addresses never target the same word in one cycle.
module sbuf_ram #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    // Write one byte per source strobe.
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    // Present the requested byte on the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem_q[raddr];
    end
endmodule

// File: rtl/sbuf_fill.sv
// Module: sbuf_fill
// Refill engine. When it is idle and a half is empty, it pulses a request,
// then counts exactly HALF_BYTES strobes into that half. If both halves are
// empty, it picks the half the reader is in first.
// Assumes: HALF_BYTES is a power of two.
module sbuf_fill
    import sbuf_pkg::*;
#(
    parameter int unsigned HALF_BYTES = 512,
    localparam int unsigned CW = $clog2(HALF_BYTES),
    localparam int unsigned AW = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    empty_i,
    input  logic          rd_half_i,
    input  logic          strobe_i,
    output logic          req_o,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic          done_o,
    output logic          done_half_o
);
    localparam logic [CW-1:0] LAST = CW'(HALF_BYTES - 1);

    fill_state_e   state_q;
    logic          half_q;
    logic [CW-1:0] cnt_q;
    logic          pick_half;

    // Choose which empty half to refill next.
    always_comb pick_half = empty_i[rd_half_i] ? rd_half_i : ~rd_half_i;

    assign we_o        = (state_q == FILL_BUSY) && strobe_i;
    assign waddr_o     = {half_q, cnt_q};
    assign done_o      = we_o && (cnt_q == LAST);
    assign done_half_o = half_q;

    // Issue requests and count strobes of the refill in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FILL_IDLE;
            half_q  <= 1'b0;
            cnt_q   <= '0;
            req_o   <= 1'b0;
        end else begin
            req_o <= 1'b0;
            unique case (state_q)
                FILL_IDLE: if (|empty_i) begin
                    req_o   <= 1'b1;
                    state_q <= FILL_BUSY;
                    half_q  <= pick_half;
                    cnt_q   <= '0;
                end
                FILL_BUSY: if (strobe_i) begin
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= FILL_IDLE;
                end
                default: state_q <= FILL_IDLE;
            endcase
        end
    end

    // R2: a request lasts one cycle.
    assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);
    // R8: a request only follows a cycle in which some half was empty.
    assert_req_needs_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> $past(|empty_i));
endmodule

// File: rtl/sbuf_drain.sv
// Module: sbuf_drain
// Read pointer for the consumer. It moves one address per accepted request
// and wraps after the last address. It flags the read that takes the last
// byte of a half.
// Assumes: HALF_BYTES is a power of two, so the pointer wraps on its own.
module sbuf_drain #(
    parameter int unsigned HALF_BYTES = 512,
    localparam int unsigned AW = $clog2(HALF_BYTES) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          req_i,
    output logic          re_o,
    output logic [AW-1:0] raddr_o,
    output logic          drained_o,
    output logic          rd_half_o
);
    logic [AW-1:0] ptr_q;

    assign re_o      = run_i && req_i;
    assign raddr_o   = ptr_q;
    assign rd_half_o = ptr_q[AW-1];
    assign drained_o = re_o && (ptr_q[AW-2:0] == '1);

    // Advance the read pointer once per accepted byte request.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr_q <= '0;
        else if (re_o) ptr_q <= ptr_q + 1'b1;
    end

    // R7: while the consumer is held, the read order does not move.
    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(ptr_q));
endmodule

// File: rtl/blk_pingpong_streamer.sv
// Module: blk_pingpong_streamer (top)
// Two-half byte buffer between a block source and a byte consumer. It tracks
// which halves are empty, holds the consumer in reset until the first block
// has arrived, and wires the refill engine and the read pointer to the storage.
// Assumes: the source answers each request with exactly HALF_BYTES strobes.
module blk_pingpong_streamer #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned HALF_BYTES = 512,
    localparam int unsigned DEPTH     = 2 * HALF_BYTES,
    localparam int unsigned AW        = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              blk_req,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    input  logic              byte_req,
    output logic [DATA_W-1:0] byte_data,
    output logic              rend_rst_n
);
    logic [1:0]    empty_q;
    logic          released_q;
    logic          we, fill_done, fill_half;
    logic [AW-1:0] waddr;
    logic          re, drained, rd_half;
    logic [AW-1:0] raddr;

    sbuf_fill #(.HALF_BYTES(HALF_BYTES)) u_fill (
        .clk(clk), .rst_n(rst_n), .empty_i(empty_q), .rd_half_i(rd_half),
        .strobe_i(src_valid), .req_o(blk_req), .we_o(we), .waddr_o(waddr),
        .done_o(fill_done), .done_half_o(fill_half)
    );

    sbuf_drain #(.HALF_BYTES(HALF_BYTES)) u_drain (
        .clk(clk), .rst_n(rst_n), .run_i(released_q), .req_i(byte_req),
        .re_o(re), .raddr_o(raddr), .drained_o(drained), .rd_half_o(rd_half)
    );

    sbuf_ram #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(src_data),
        .re(re), .raddr(raddr), .rdata(byte_data)
    );

    // Mark halves full on refill completion and empty after their last read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 2'b11;
        end else begin
            if (fill_done) empty_q[fill_half] <= 1'b0;
            if (drained)   empty_q[rd_half]   <= 1'b1;
        end
    end

    // Release the consumer once the first block is complete.
    always_ff @(posedge clk) begin
        if (!rst_n)         released_q <= 1'b0;
        else if (fill_done) released_q <= 1'b1;
    end

    assign rend_rst_n = released_q;

    // R4: once released, the consumer stays released.
    assert_release_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rend_rst_n |=> rend_rst_n);
    // R4: the release follows a completed refill.
    assert_release_after_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rend_rst_n) |-> $past(fill_done));
    // R7: no byte moves to the consumer while it is held in reset.
    assert_no_read_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rend_rst_n |=> $stable(byte_data));
endmodule

// File: tb/tb_blk_pingpong_streamer.sv
module tb_blk_pingpong_streamer;
    localparam int W  = 8;
    localparam int HB = 512;
    // Block patterns: {first byte, increment}; byte i = first + i*increment.
    localparam logic [15:0] PATS [4] = '{16'h3C01, 16'hA503, 16'h5A07, 16'hFFFD};

    logic         clk = 1'b0;
    logic         rst_n, blk_req, src_valid, byte_req, rend_rst_n;
    logic [W-1:0] src_data, byte_data;
    int           checks = 0, fails = 0, req_cnt = 0;
    logic         req_prev = 1'b0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    blk_pingpong_streamer #(.DATA_W(W), .HALF_BYTES(HB)) dut (
        .clk(clk), .rst_n(rst_n), .blk_req(blk_req), .src_valid(src_valid),
        .src_data(src_data), .byte_req(byte_req), .byte_data(byte_data),
        .rend_rst_n(rend_rst_n)
    );

    function automatic logic [7:0] pat_byte(int p, int i);
        logic [15:0] e;
        e = PATS[p];
        return 8'(int'(e[15:8]) + i * int'(e[7:0]));
    endfunction

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock; sample outputs at the falling edge and track request pulses.
    task automatic cyc();
        @(negedge clk);
        if (blk_req) begin
            req_cnt++;
            if (req_prev) check_eq("R2", "request pulse width", 2, 1);
        end
        req_prev = blk_req;
    endtask

    task automatic strobe(int p, int i);
        src_valid = 1'b1;
        src_data  = pat_byte(p, i);
        cyc();
        src_valid = 1'b0;
    endtask

    task automatic read_chk(int p, int i, string r);
        byte_req = 1'b1;
        cyc();
        byte_req = 1'b0;
        check_eq(r, "byte", int'(byte_data), int'(pat_byte(p, i)));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; src_valid = 1'b0; src_data = '0; byte_req = 1'b0;
        repeat (3) cyc();
        check_eq("R1", "reset blk_req", int'(blk_req), 0);
        check_eq("R1", "reset rend_rst_n", int'(rend_rst_n), 0);
        check_eq("R1", "reset byte_data", int'(byte_data), 0);
        req_cnt = 0;
        rst_n = 1'b1;
        cyc();
        check_eq("R1", "first request", int'(blk_req), 1);

        // First block: consumer held until the final strobe.
        for (int i = 0; i < HB - 1; i++) strobe(0, i);
        check_eq("R4", "held before last strobe", int'(rend_rst_n), 0);
        check_eq("R2", "no request during refill", req_cnt, 1);
        byte_req = 1'b1; cyc(); byte_req = 1'b0;
        check_eq("R7", "read while held", int'(byte_data), 0);
        strobe(0, HB - 1);
        check_eq("R4", "released", int'(rend_rst_n), 1);
        check_eq("R5", "no request yet", int'(blk_req), 0);
        cyc();
        check_eq("R5", "second half request", int'(blk_req), 1);
        for (int i = 0; i < HB; i++) strobe(1, i);

        // Stray strobes with no refill outstanding.
        for (int i = 0; i < 16; i++) begin
            src_valid = 1'b1; src_data = 8'hEE; cyc();
        end
        src_valid = 1'b0;
        repeat (4) cyc();
        check_eq("R3", "no request from stray strobes", req_cnt, 2);

        // Table walk over the first half (R6; R7 order kept).
        for (int i = 0; i < HB; i++) read_chk(0, i, "R6");
        check_eq("R8", "request one cycle later", int'(blk_req), 0);
        cyc();
        check_eq("R8", "refill request lower half", int'(blk_req), 1);
        check_eq("R8", "request count", req_cnt, 3);

        // Overlap: strobes into lower half while reading upper half.
        for (int i = 0; i < HB / 2; i++) begin
            src_valid = 1'b1; src_data = pat_byte(2, i); byte_req = 1'b1;
            cyc();
            check_eq("R6", "read during refill", int'(byte_data), int'(pat_byte(1, i)));
        end
        src_valid = 1'b0; byte_req = 1'b0;
        for (int i = HB / 2; i < HB; i++) read_chk(1, i, "R3");
        repeat (3) cyc();
        check_eq("R2", "deferred while counting", req_cnt, 3);
        for (int i = HB / 2; i < HB - 1; i++) strobe(2, i);
        check_eq("R2", "still deferred", req_cnt, 3);
        strobe(2, HB - 1);
        check_eq("R8", "no deferred request yet", int'(blk_req), 0);
        cyc();
        check_eq("R8", "deferred request", int'(blk_req), 1);
        for (int i = 0; i < HB; i++) strobe(3, i);

        // Read wraps from 1023 to 0, then into the refilled upper half.
        for (int i = 0; i < HB; i++) read_chk(2, i, "R6");
        for (int i = 0; i < 4; i++) read_chk(3, i, "R8");

        // Restart in mid-run.
        rst_n = 1'b0; cyc();
        check_eq("R9", "blk_req after reset", int'(blk_req), 0);
        check_eq("R9", "rend_rst_n after reset", int'(rend_rst_n), 0);
        check_eq("R9", "byte_data after reset", int'(byte_data), 0);
        cyc();
        rst_n = 1'b1; cyc();
        check_eq("R9", "request after restart", int'(blk_req), 1);
        for (int i = 0; i < HB; i++) strobe(1, i);
        check_eq("R9", "released after restart", int'(rend_rst_n), 1);
        for (int i = 0; i < 4; i++) read_chk(1, i, "R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule